// File: doc/BRIEF.md
# Odd-Aware Square Wave Divider

The block divides its clock by a programmable count N and drives a square wave that toggles once per half-period. A down-counter is loaded with N at the start of every half-period and normally loses two per clock. When it reaches zero the output toggles and N is loaded again. For an odd N, the first step of a half-period is 1 while the output is high and 3 while it is low. The high phase therefore lasts one clock longer than the low phase.

Software loads the count one byte at a time over a valid/ready byte stream: the low byte first, then the high byte. `wr_ready` is held high, so the stream never applies back-pressure and a byte is taken on every clock edge where `wr_valid` is high. A gate input controls the waveform. While the gate is low the output is held high. When the gate rises, the waveform restarts from a fresh high phase.

Top module: `sqw_divider`

## Requirements
- R1: After reset, and until a legal count has been accepted, `sq_out` stays high and never toggles; `wr_ready` is high at all times.
- R2: Accepted bytes alternate. The first byte after reset is bits 7:0 of the count and the next byte is bits 15:8. The count is used only once its second byte has been accepted.
- R3: For an even N, `sq_out` is high for N/2 clocks and low for N/2 clocks, repeating.
- R4: For an odd N, `sq_out` is high for (N+1)/2 clocks and low for (N-1)/2 clocks, repeating.
- R5: The first legal count accepted after reset starts a high phase at the accepting clock edge. That phase lasts the full high length for that count.
- R6: A count accepted while the waveform runs leaves the half-period in progress unchanged. It applies from the next toggle onward.
- R7: A count value of 0 acts as 65536, giving a 32768-clock high phase.
- R8: A count value of 1 is rejected. The previous count, or the unloaded state, is kept, and the next byte is again taken as a low byte.
- R9: While `gate` is low, `sq_out` is high from the clock edge after `gate` was sampled low.
- R10: A rising `gate` reloads the latest count and restarts a high phase of the full high length, counted from the edge where the rise is sampled.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Counter clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| gate | input | 1 | Run enable: low holds the output high, a rise restarts the waveform |
| wr_valid | input | 1 | Byte write valid |
| wr_ready | output | 1 | Byte write ready, always high |
| wr_data | input | 8 | Count byte, low byte first then high byte |
| sq_out | output | 1 | Square wave output |

## Verification
Internal faults in this block appear at the output as phase lengths that are wrong. A wrong step size, parity choice or terminal test changes the high or low run length within the first half-period after a load. A byte-pointer fault shows as a different period after the next write. The bench sweeps every count from 2 to 33 and measures successive high and low runs against N/2 arithmetic. It then covers mid-phase writes, the rejected value, gate hold and restart, a count that uses the high byte, and the zero count.

// File: rtl/sqw_pkg.sv
package sqw_pkg;

  typedef enum logic {
    BYTE_LO = 1'b0,
    BYTE_HI = 1'b1
  } byte_sel_e;

  // Step taken by the down-counter in one clock.
  // An odd value is only seen on the first clock of a half-period.
  function automatic logic [1:0] step_size(input logic cnt_odd, input logic phase_high);
    if (!cnt_odd)       return 2'd2;
    else if (phase_high) return 2'd1;
    else                 return 2'd3;
  endfunction

endpackage

// File: rtl/sqw_gate_edge.sv
module sqw_gate_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic gate,
  output logic gate_rise
);

  logic gate_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) gate_q <= 1'b0;
    else        gate_q <= gate;
  end

  assign gate_rise = gate && !gate_q;

endmodule

// File: rtl/sqw_count_loader.sv
module sqw_count_loader #(
  parameter int BYTE_W = 8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                wr_valid,
  input  logic [BYTE_W-1:0]   wr_data,
  output logic                armed,
  output logic                accept,
  output logic [2*BYTE_W:0]   n_eff
);
  import sqw_pkg::*;

  localparam int CNT_W = 2 * BYTE_W;
  localparam int REG_W = CNT_W + 1;
  localparam logic [REG_W-1:0] FULL_CNT = {1'b1, {CNT_W{1'b0}}};

  byte_sel_e          sel_q;
  logic [BYTE_W-1:0]  lo_q;
  logic [REG_W-1:0]   n_q;
  logic               armed_q;
  logic [CNT_W-1:0]   raw;
  logic [REG_W-1:0]   cand;
  logic               legal;

  always_comb begin
    raw    = {wr_data, lo_q};
    cand   = (raw == '0) ? FULL_CNT : {1'b0, raw};
    legal  = (raw != CNT_W'(1));
    accept = wr_valid && (sel_q == BYTE_HI) && legal;
    n_eff  = accept ? cand : n_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sel_q   <= BYTE_LO;
      lo_q    <= '0;
      n_q     <= FULL_CNT;
      armed_q <= 1'b0;
    end else if (wr_valid) begin
      if (sel_q == BYTE_LO) begin
        lo_q  <= wr_data;
        sel_q <= BYTE_HI;
      end else begin
        sel_q <= BYTE_LO;
        if (legal) begin
          n_q     <= cand;
          armed_q <= 1'b1;
        end
      end
    end
  end

  assign armed = armed_q;

  // R8
  n_legal_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed_q |-> (n_q >= REG_W'(2)));

endmodule

// File: rtl/sqw_phase_gen.sv
module sqw_phase_gen #(
  parameter int REG_W = 17
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             armed,
  input  logic             gate,
  input  logic             restart,
  input  logic [REG_W-1:0] n_eff,
  output logic             sq
);
  import sqw_pkg::*;

  logic [REG_W-1:0] cnt_q;
  logic             out_q;
  logic [REG_W-1:0] step_ext;

  assign step_ext = REG_W'(step_size(cnt_q[0], out_q));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      out_q <= 1'b1;
    end else if (restart) begin
      cnt_q <= n_eff;
      out_q <= 1'b1;
    end else if (!armed || !gate) begin
      out_q <= 1'b1;
    end else if (cnt_q <= step_ext) begin
      out_q <= ~out_q;
      cnt_q <= n_eff;
    end else begin
      cnt_q <= cnt_q - step_ext;
    end
  end

  assign sq = out_q;

  // R3
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    armed |-> (cnt_q != '0));

  // R4
  no_early_toggle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (armed && gate && !restart && cnt_q > REG_W'(3)) |=> $stable(out_q));

  // R9
  gate_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !gate |=> out_q);

endmodule

// File: rtl/sqw_divider.sv
module sqw_divider #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate,
  input  logic              wr_valid,
  output logic              wr_ready,
  input  logic [BYTE_W-1:0] wr_data,
  output logic              sq_out
);

  localparam int REG_W = 2 * BYTE_W + 1;

  logic             armed;
  logic             accept;
  logic [REG_W-1:0] n_eff;
  logic             gate_rise;
  logic             restart;

  assign wr_ready = 1'b1;

  sqw_count_loader #(.BYTE_W(BYTE_W)) u_loader (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_valid (wr_valid),
    .wr_data  (wr_data),
    .armed    (armed),
    .accept   (accept),
    .n_eff    (n_eff)
  );

  sqw_gate_edge u_gate (
    .clk       (clk),
    .rst_n     (rst_n),
    .gate      (gate),
    .gate_rise (gate_rise)
  );

  // First legal count starts the waveform; later a gate rise restarts it.
  assign restart = (accept && !armed) || (gate_rise && armed);

  sqw_phase_gen #(.REG_W(REG_W)) u_phase (
    .clk     (clk),
    .rst_n   (rst_n),
    .armed   (armed),
    .gate    (gate),
    .restart (restart),
    .n_eff   (n_eff),
    .sq      (sq_out)
  );

  // R1
  idle_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !armed |-> sq_out);

  // R10
  restart_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> sq_out);

endmodule

// File: tb/tb_sqw_divider.sv
module tb_sqw_divider;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       gate = 1'b1;
  logic       wr_valid = 1'b0;
  logic [7:0] wr_data = 8'h00;
  logic       wr_ready;
  logic       sq_out;

  int total = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk = ~clk;

  sqw_divider dut (
    .clk      (clk),
    .rst_n    (rst_n),
    .gate     (gate),
    .wr_valid (wr_valid),
    .wr_ready (wr_ready),
    .wr_data  (wr_data),
    .sq_out   (sq_out)
  );

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  task automatic write_count(input logic [15:0] v);
    @(negedge clk);
    wr_valid = 1'b1;
    wr_data  = v[7:0];
    @(negedge clk);
    wr_data  = v[15:8];
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic wait_level(input logic v);
    int guard = 0;
    while (sq_out != v && guard < 70000) begin
      guard++;
      @(negedge clk);
    end
  endtask

  // Counts samples at the current level, starting with the current one.
  task automatic measure_run(input logic v, output int len);
    len = 0;
    while (sq_out == v && len < 70000) begin
      len++;
      @(negedge clk);
    end
  endtask

  initial begin : main
    int h, l, l2, lows;
    do_reset();
    @(negedge clk);
    // R1: reset state
    chk("R1 reset output", int'(sq_out), 1);
    chk("R1 ready", int'(wr_ready), 1);
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!sq_out) lows++;
    end
    chk("R1 no toggle unloaded", lows, 0);

    // R5: first count starts a high phase at once (N=5)
    write_count(16'd5);
    measure_run(1'b1, h);
    chk("R5 first high", h, 3);
    measure_run(1'b0, l);
    chk("R5 first low", l, 2);

    // R3 / R4: sweep counts 2..33
    for (int n = 2; n <= 33; n++) begin
      write_count(16'(n));
      wait_level(1'b1);
      wait_level(1'b0);
      measure_run(1'b0, l);
      measure_run(1'b1, h);
      measure_run(1'b0, l2);
      if (n % 2 == 0) begin
        chk($sformatf("R3 low N=%0d", n), l, n / 2);
        chk($sformatf("R3 high N=%0d", n), h, n / 2);
        chk($sformatf("R3 low2 N=%0d", n), l2, n / 2);
      end else begin
        chk($sformatf("R4 low N=%0d", n), l, (n - 1) / 2);
        chk($sformatf("R4 high N=%0d", n), h, (n + 1) / 2);
        chk($sformatf("R4 low2 N=%0d", n), l2, (n - 1) / 2);
      end
    end

    // R6: write 8 during a high phase of N=20
    write_count(16'd20);
    wait_level(1'b0);
    wait_level(1'b1);
    fork
      write_count(16'd8);
      measure_run(1'b1, h);
    join
    chk("R6 phase in progress", h, 10);
    measure_run(1'b0, l);
    chk("R6 next low", l, 4);
    measure_run(1'b1, h);
    chk("R6 next high", h, 4);

    // R8: count 1 rejected while running, byte pointer realigned
    write_count(16'd1);
    wait_level(1'b1);
    wait_level(1'b0);
    measure_run(1'b0, l);
    measure_run(1'b1, h);
    chk("R8 old count low", l, 4);
    chk("R8 old count high", h, 4);
    write_count(16'd6);
    wait_level(1'b1);
    wait_level(1'b0);
    measure_run(1'b0, l);
    measure_run(1'b1, h);
    chk("R8 next write low", l, 3);
    chk("R8 next write high", h, 3);

    // R9: drop gate during a low phase
    wait_level(1'b0);
    gate = 1'b0;
    lows = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk);
      if (!sq_out) lows++;
    end
    chk("R9 held high", lows, 0);

    // R10: write 9 while gated, then raise gate
    write_count(16'd9);
    lows = 0;
    for (int i = 0; i < 5; i++) begin
      @(negedge clk);
      if (!sq_out) lows++;
    end
    chk("R9 held high after write", lows, 0);
    gate = 1'b1;
    @(negedge clk);
    measure_run(1'b1, h);
    chk("R10 restart high", h, 5);
    measure_run(1'b0, l);
    chk("R10 restart low", l, 4);

    // R2: high byte in use (N=258)
    @(negedge clk);
    gate = 1'b0;
    write_count(16'd258);
    gate = 1'b1;
    @(negedge clk);
    measure_run(1'b1, h);
    chk("R2 high byte high", h, 129);
    measure_run(1'b0, l);
    chk("R2 high byte low", l, 129);

    // R7: zero count acts as 65536
    @(negedge clk);
    gate = 1'b0;
    write_count(16'd0);
    gate = 1'b1;
    @(negedge clk);
    measure_run(1'b1, h);
    chk("R7 zero count high", h, 32768);

    // R8: count 1 after reset leaves the block unloaded
    do_reset();
    write_count(16'd1);
    lows = 0;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      if (!sq_out) lows++;
    end
    chk("R8 unloaded after reject", lows, 0);
    // R2: the next pair is taken as low then high byte (N=4)
    write_count(16'd4);
    measure_run(1'b1, h);
    chk("R2 realigned high", h, 2);
    measure_run(1'b0, l);
    chk("R2 realigned low", l, 2);

    done = 1'b1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      total++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

endmodule